// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Command Engine

This block is the device side of a serial flash memory reached over a four-wire SPI link in mode 0. The array is organised in pages, and two page-sized SRAM buffers sit beside it. A frame opens when `cs_n` falls. Its first byte is an opcode, and the next three bytes form a 24-bit address sent MSB first. Bits [8:0] of that address are the byte offset inside a page and bits [12:9] are the page number. The remaining address bits are ignored. When the offset is past the last byte of a page, it wraps by subtracting the page size. Data bytes follow the address. Several devices can share the bus, because SO stays low whenever this device is deselected.

Buffer reads and writes, direct page reads and status reads all complete within the frame. Transfer, compare, program and erase start when `cs_n` rises. Each then holds `busy` high for a parameter-set number of clock cycles, and during that time it walks the page one byte per cycle. The array is a small register model with 16 pages of 264 bytes. The model counts cycles and does not model cell physics. Program without erase can only clear bits. A `protect_n` input guards the lowest pages, and `rst_n` aborts any operation that is running.

The SPI pins are sampled by the system clock through two-stage synchronisers. Each SCK half period must therefore last at least four clock cycles.

Top module: `sflash_cmd_engine`

## Requirements
- R1: SPI mode 0 framing. SI is captured on SCK rising edges and SO advances on SCK falling edges, MSB first. SO is 0 while `cs_n` is high.
- R2: Buffer write uses opcodes 0x11 (buffer A) and 0x12 (buffer B). Buffer read uses 0x21 (A) and 0x22 (B). Both take three address bytes, store or return consecutive bytes from the offset, and wrap from byte 263 to byte 0. The two buffers are independent.
- R3: Opcode 0x0B streams array bytes of the addressed page from the offset, wrapping within the page.
- R4: Opcodes 0x31 and 0x32 copy the addressed page into buffer A or B, with `busy` high for exactly T_XFER cycles.
- R5: Opcodes 0x41 and 0x42 compare the page with buffer A or B for T_XFER cycles. Status bit 6 becomes 1 if any byte differs and 0 if all bytes match. It keeps that value until the next compare ends.
- R6: Opcodes 0x51 and 0x52 erase the page and then program it from buffer A or B, so the page equals the buffer. `busy` is high for T_PROG cycles.
- R7: Opcodes 0x61 and 0x62 program without erase: each new byte is the old byte AND the buffer byte. `busy` is high for T_PROG cycles.
- R8: Opcodes 0x71 and 0x72 write the data bytes into buffer A or B, then erase and program the page from that buffer when `cs_n` rises. `busy` is high for T_PROG cycles.
- R9: Opcode 0x81 sets every byte of the page to FFh in T_ERASE cycles. Opcode 0x91 does the same for the 8-page aligned block that holds the page (page bits [3:0] with bits [2:0] masked) in T_BLOCK cycles. Pages outside the block are untouched.
- R10: Opcode 0x05 returns the status byte repeatedly. The byte is {ready, mismatch, protect_reject, 5'b0}, with ready = 1 when idle. The status read works while busy.
- R11: While `busy` is high, every opcode except 0x05 is ignored, including its data and any launch at `cs_n` rise.
- R12: While `protect_n` is low, a program or erase whose target page (for block erase, the block base page) is below PROT_PAGES does not start and sets status bit 5. A program or erase that is accepted clears bit 5.
- R13: `rst_n` low ends any running operation at once and clears the status flags. Array bytes the operation has not yet reached keep their values.
- R14: An internal operation starts only when `cs_n` rises after the opcode and all three address bytes. Shorter frames do nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset and operation abort |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| protect_n | input | 1 | Active-low protection of the lowest pages |
| so | output | 1 | Serial data out |
| busy | output | 1 | High while an internal operation runs |

## Verification
The assertions check five properties on every clock:
- `busy` only rises right after a chip-select release (R14).
- The captured operation and its base address hold steady while it runs (R11).
- No protected page is ever targeted by an accepted program or erase (R12).
- Each busy period lasts exactly the duration set for its kind of operation (R4, R6, R9).
- `busy` is low once reset is released (R13).

Only the bench's scenarios can show the data-level results:
- the AND rule of program without erase;
- compare outcomes;
- block boundaries;
- offset wrap;
- which bytes survive an aborted erase;
- that writes issued during busy leave the buffer unchanged.

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine #(
  parameter int PAGE_BYTES  = 264,
  parameter int NUM_PAGES   = 16,
  parameter int BLOCK_PAGES = 8,
  parameter int PROT_PAGES  = 2,
  parameter int T_XFER      = 300,
  parameter int T_ERASE     = 600,
  parameter int T_PROG      = 900,
  parameter int T_BLOCK     = 2400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic protect_n,
  output logic so,
  output logic busy
);
  localparam int MEM_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int AW = $clog2(MEM_BYTES);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int PW = $clog2(NUM_PAGES);
  localparam int QW = OW + PW;
  localparam int TW = $clog2(T_BLOCK + BLOCK_PAGES * PAGE_BYTES + 1);

  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_PREAD = 8'h0B;

  localparam logic [2:0] K_XFER  = 3'd0;
  localparam logic [2:0] K_CMP   = 3'd1;
  localparam logic [2:0] K_PGME  = 3'd2;
  localparam logic [2:0] K_PGM   = 3'd3;
  localparam logic [2:0] K_ERASE = 3'd4;
  localparam logic [2:0] K_BLK   = 3'd5;

  logic [7:0] mem  [MEM_BYTES];
  logic [7:0] bufm [2][PAGE_BYTES];

  logic [2:0] sck_q, cs_q;
  logic [1:0] si_q;
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire sel      = ~cs_q[1];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire si_s     = si_q[1];

  logic [2:0]    bit_cnt, byte_cnt;
  logic [6:0]    rx_sr;
  logic [7:0]    opc, tx_sr;
  logic [QW-1:0] addr_q;
  logic [OW-1:0] ptr;
  logic          ign, load_pend;

  logic [2:0]    op_q;
  logic [AW-1:0] base_q;
  logic          obuf_q;
  logic [TW-1:0] cnt_q, last_q, len_q;
  logic          busy_q, mis_acc, mis_q, rej_q;

  wire [7:0]    rx_byte  = {rx_sr, si_s};
  wire          byte_done = sel & sck_rise & (bit_cnt == 3'd7);
  wire [QW-1:0] addr_nx  = {addr_q[QW-9:0], rx_byte};
  wire [OW-1:0] off_raw  = addr_nx[OW-1:0];
  wire [OW-1:0] off0     = (off_raw >= OW'(PAGE_BYTES)) ? off_raw - OW'(PAGE_BYTES) : off_raw;
  wire [PW-1:0] pg       = addr_q[QW-1:OW];
  wire [OW-1:0] ptr_inc  = (ptr == OW'(PAGE_BYTES - 1)) ? '0 : ptr + 1'b1;

  wire [3:0] hi     = opc[7:4];
  wire       lo_ok  = (opc[3:0] == 4'h1) || (opc[3:0] == 4'h2);
  wire       bsel   = opc[1];
  wire       is_stat  = (opc == OP_STAT);
  wire       is_pread = (opc == OP_PREAD);
  wire       is_brd   = (hi == 4'h2) && lo_ok;
  wire       is_bwr   = ((hi == 4'h1) || (hi == 4'h7)) && lo_ok;
  wire       rd_cmd   = is_pread || is_brd;

  wire [7:0]    status    = {~busy_q, mis_q, rej_q, 5'b0};
  wire [AW-1:0] page_base = AW'(pg) * AW'(PAGE_BYTES);
  wire [AW-1:0] rd_idx    = page_base + AW'(ptr);
  wire [7:0]    tx_src    = is_stat ? status : (is_pread ? mem[rd_idx] : bufm[bsel][ptr]);

  logic [2:0]    kind;
  logic          kind_ok;
  logic [TW-1:0] dur;
  always_comb begin
    kind    = K_XFER;
    kind_ok = 1'b0;
    case (hi)
      4'h3: begin kind = K_XFER;  kind_ok = lo_ok; end
      4'h4: begin kind = K_CMP;   kind_ok = lo_ok; end
      4'h5: begin kind = K_PGME;  kind_ok = lo_ok; end
      4'h6: begin kind = K_PGM;   kind_ok = lo_ok; end
      4'h7: begin kind = K_PGME;  kind_ok = lo_ok; end
      4'h8: begin kind = K_ERASE; kind_ok = (opc[3:0] == 4'h1); end
      4'h9: begin kind = K_BLK;   kind_ok = (opc[3:0] == 4'h1); end
      default: ;
    endcase
    case (kind)
      K_XFER, K_CMP: dur = TW'(T_XFER - 1);
      K_ERASE:       dur = TW'(T_ERASE - 1);
      K_BLK:         dur = TW'(T_BLOCK - 1);
      default:       dur = TW'(T_PROG - 1);
    endcase
  end

  wire [PW-1:0] tgt_page = (kind == K_BLK) ? (pg & ~PW'(BLOCK_PAGES - 1)) : pg;
  wire modify   = (kind == K_PGME) || (kind == K_PGM) || (kind == K_ERASE) || (kind == K_BLK);
  wire prot_hit = !protect_n && modify && (tgt_page < PW'(PROT_PAGES));
  wire want     = cs_rise && (byte_cnt == 3'd4) && !ign && kind_ok;
  wire launch   = want && !prot_hit && !busy_q;

  wire          walk = busy_q && (cnt_q < len_q);
  wire [AW-1:0] widx = base_q + AW'(cnt_q);
  wire [OW-1:0] bidx = cnt_q[OW-1:0];
  wire [7:0]    m_rd = mem[widx];
  wire [7:0]    b_rd = bufm[obuf_q][bidx];
  wire          diff = walk && (m_rd != b_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; si_q <= '0;
      bit_cnt <= '0; byte_cnt <= '0; rx_sr <= '0; opc <= '0; tx_sr <= '0;
      addr_q <= '0; ptr <= '0; ign <= 1'b0; load_pend <= 1'b0;
      busy_q <= 1'b0; op_q <= K_XFER; base_q <= '0; obuf_q <= 1'b0;
      cnt_q <= '0; last_q <= '0; len_q <= '0;
      mis_acc <= 1'b0; mis_q <= 1'b0; rej_q <= 1'b0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
      si_q  <= {si_q[0], si};

      if (!sel) begin
        bit_cnt <= '0; byte_cnt <= '0; tx_sr <= '0; ign <= 1'b0; load_pend <= 1'b0;
      end else begin
        load_pend <= 1'b0;
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 1'b1;
          rx_sr   <= {rx_sr[5:0], si_s};
        end
        if (sck_fall && bit_cnt != 3'd0) tx_sr <= {tx_sr[6:0], 1'b0};
        if (byte_done) begin
          if (byte_cnt != 3'd4) byte_cnt <= byte_cnt + 1'b1;
          case (byte_cnt)
            3'd0: begin
              opc       <= rx_byte;
              ign       <= busy_q && (rx_byte != OP_STAT);
              load_pend <= (rx_byte == OP_STAT);
            end
            3'd1, 3'd2: begin
              addr_q    <= addr_nx;
              load_pend <= is_stat;
            end
            3'd3: begin
              addr_q    <= addr_nx;
              ptr       <= off0;
              load_pend <= is_stat || (!ign && rd_cmd);
            end
            default: begin
              if (!ign && is_bwr) ptr <= ptr_inc;
              load_pend <= is_stat || (!ign && rd_cmd);
            end
          endcase
        end
        if (load_pend) begin
          tx_sr <= tx_src;
          if (rd_cmd) ptr <= ptr_inc;
        end
      end

      if (launch) begin
        busy_q  <= 1'b1;
        op_q    <= kind;
        base_q  <= AW'(tgt_page) * AW'(PAGE_BYTES);
        obuf_q  <= bsel;
        cnt_q   <= '0;
        last_q  <= dur;
        len_q   <= (kind == K_BLK) ? TW'(BLOCK_PAGES * PAGE_BYTES) : TW'(PAGE_BYTES);
        mis_acc <= 1'b0;
        if (modify) rej_q <= 1'b0;
      end else if (want && prot_hit) begin
        rej_q <= 1'b1;
      end

      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (op_q == K_CMP && diff) mis_acc <= 1'b1;
        if (cnt_q == last_q) begin
          busy_q <= 1'b0;
          if (op_q == K_CMP) mis_q <= mis_acc | diff;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (walk) begin
      case (op_q)
        K_XFER:         bufm[obuf_q][bidx] <= m_rd;
        K_PGME:         mem[widx] <= b_rd;
        K_PGM:          mem[widx] <= m_rd & b_rd;
        K_ERASE, K_BLK: mem[widx] <= 8'hFF;
        default: ;
      endcase
    end else if (byte_done && byte_cnt == 3'd4 && !ign && is_bwr) begin
      bufm[bsel][ptr] <= rx_byte;
    end
  end

  assign so   = sel & tx_sr[7];
  assign busy = busy_q;
endmodule

// File: rtl/sflash_cmd_engine_chk.sv
module sflash_cmd_engine_chk #(
  parameter int AW = 13,
  parameter int PAGE_BYTES = 264,
  parameter int PROT_PAGES = 2,
  parameter int T_XFER = 300,
  parameter int T_ERASE = 600,
  parameter int T_PROG = 900,
  parameter int T_BLOCK = 2400
) (
  input logic          clk,
  input logic          rst_n,
  input logic          protect_n,
  input logic          busy,
  input logic          cs_rise,
  input logic [2:0]    op_q,
  input logic [AW-1:0] base_q
);
  logic [15:0] run_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 16'd1;
    else           run_len <= '0;

  logic [15:0] exp_len;
  always_comb
    case (op_q)
      3'd0, 3'd1: exp_len = 16'(T_XFER);
      3'd4:       exp_len = 16'(T_ERASE);
      3'd5:       exp_len = 16'(T_BLOCK);
      default:    exp_len = 16'(T_PROG);
    endcase

  wire modify = (op_q >= 3'd2) && (op_q <= 3'd5);

  p_launch_on_release_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  p_op_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(base_q)));

  p_guarded_pages_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && modify && !$past(protect_n)) |-> (base_q >= AW'(PROT_PAGES * PAGE_BYTES)));

  // also covers R4 and R6 durations
  p_busy_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == exp_len));

  p_idle_after_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !busy);
endmodule

bind sflash_cmd_engine sflash_cmd_engine_chk #(
  .AW(AW), .PAGE_BYTES(PAGE_BYTES), .PROT_PAGES(PROT_PAGES),
  .T_XFER(T_XFER), .T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_BLOCK(T_BLOCK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .protect_n(protect_n), .busy(busy),
  .cs_rise(cs_rise), .op_q(op_q), .base_q(base_q)
);

// File: tb/sflash_cmd_engine_test.sv
`timescale 1ns/1ps
module sflash_cmd_engine_test;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, protect_n = 1'b1;
  wire  so, busy;

  sflash_cmd_engine uut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
                         .protect_n(protect_n), .so(so), .busy(busy));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] exp_v[$];
  string      exp_t[$];
  logic [7:0] act_q[$];

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_v.push_back(v);
    exp_t.push_back(tag);
  endtask

  initial forever begin
    @(posedge clk);
    while (act_q.size() > 0) begin
      logic [7:0] a;
      a = act_q.pop_front();
      if (exp_v.size() == 0) check(a, -1, "scoreboard underflow");
      else check(a, exp_v.pop_front(), exp_t.pop_front());
    end
  end

  task automatic spi_byte(input logic [7:0] tx, input bit cap);
    logic [7:0] rx;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      #50;
      rx[i] = so;
      sck = 1'b1;
      #50;
      sck = 1'b0;
    end
    if (cap) act_q.push_back(rx);
  endtask

  task automatic open_hdr(input logic [7:0] op, input int page, input int off);
    logic [23:0] a;
    a = 24'((page << 9) | off);
    cs_n = 1'b0;
    #50;
    spi_byte(op, 0);
    spi_byte(a[23:16], 0);
    spi_byte(a[15:8], 0);
    spi_byte(a[7:0], 0);
  endtask

  task automatic close_frame();
    #50; cs_n = 1'b1; #100;
  endtask

  task automatic rd(input logic [7:0] op, input int page, input int off, input int n);
    open_hdr(op, page, off);
    repeat (n) spi_byte(8'h00, 1);
    close_frame();
  endtask

  task automatic status_is(input logic [7:0] v, input string tag);
    expect_byte(v, tag);
    cs_n = 1'b0; #50;
    spi_byte(8'h05, 0);
    spi_byte(8'h00, 1);
    close_frame();
  endtask

  task automatic close_and_time(input int exp, input string tag);
    int cnt = 0, guard = 0;
    bit seen = 0;
    #50; cs_n = 1'b1;
    while (guard < 5000) begin
      @(posedge clk); #1;
      guard++;
      if (busy) begin seen = 1; cnt++; end
      else if (seen) break;
    end
    check(cnt, exp, tag);
    #100;
  endtask

  task automatic run_op(input logic [7:0] op, input int page, input int exp, input string tag);
    open_hdr(op, page, 0);
    close_and_time(exp, tag);
  endtask

  task automatic stays_idle(input int n, input string tag);
    int hits = 0;
    repeat (n) begin @(posedge clk); #1; if (busy) hits++; end
    check(hits, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, 1, "watchdog R1..R14 run hung");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    #30 rst_n = 1'b1;
    #70;
    check(busy, 0, "R13 reset busy low");
    check(so, 0, "R1 so low while deselected");
    status_is(8'h80, "R10 idle status");

    // R1: repeated status bytes, MSB first
    expect_byte(8'h80, "R1 status byte 1");
    expect_byte(8'h80, "R10 status repeat");
    cs_n = 1'b0; #50; spi_byte(8'h05, 0); spi_byte(8'h00, 1); spi_byte(8'h00, 1); close_frame();

    // R2: buffer write/read, independence, wrap
    open_hdr(8'h11, 0, 10); spi_byte(8'hAA, 0); spi_byte(8'h55, 0); spi_byte(8'h0F, 0); close_frame();
    open_hdr(8'h12, 0, 10); spi_byte(8'h3C, 0); spi_byte(8'hF0, 0); close_frame();
    open_hdr(8'h11, 0, 263); spi_byte(8'h77, 0); spi_byte(8'h88, 0); close_frame();
    expect_byte(8'hAA, "R2 bufA[10]"); expect_byte(8'h55, "R2 bufA[11]"); expect_byte(8'h0F, "R2 bufA[12]");
    rd(8'h21, 0, 10, 3);
    expect_byte(8'h3C, "R2 bufB[10]"); expect_byte(8'hF0, "R2 bufB[11]");
    rd(8'h22, 0, 10, 2);
    expect_byte(8'h77, "R2 bufA[263]"); expect_byte(8'h88, "R2 bufA wrap to 0");
    rd(8'h21, 0, 263, 2);

    // R9/R3: page erase then read
    run_op(8'h81, 4, 600, "R9 page erase duration");
    expect_byte(8'hFF, "R3 erased byte"); expect_byte(8'hFF, "R9 erased byte");
    rd(8'h0B, 4, 100, 2);

    // R6: program with erase from A
    run_op(8'h51, 4, 900, "R6 program duration");
    expect_byte(8'hAA, "R6 page4[10]"); expect_byte(8'h55, "R6 page4[11]");
    rd(8'h0B, 4, 10, 2);
    expect_byte(8'h77, "R3 page4[263]"); expect_byte(8'h88, "R3 page read wrap");
    rd(8'h0B, 4, 263, 2);

    // R7: program without erase from B (AND)
    run_op(8'h62, 4, 900, "R7 program duration");
    expect_byte(8'h28, "R7 AA&3C"); expect_byte(8'h50, "R7 55&F0");
    rd(8'h0B, 4, 10, 2);

    // R4: transfer page to B
    open_hdr(8'h12, 0, 10); spi_byte(8'h00, 0); spi_byte(8'h00, 0); close_frame();
    run_op(8'h32, 4, 300, "R4 transfer duration");
    expect_byte(8'h28, "R4 bufB[10]"); expect_byte(8'h50, "R4 bufB[11]");
    rd(8'h22, 0, 10, 2);

    // R5: compare match, then mismatch
    run_op(8'h42, 4, 300, "R5 compare duration");
    status_is(8'h80, "R5 match clears flag");
    open_hdr(8'h12, 0, 10); spi_byte(8'h00, 0); close_frame();
    run_op(8'h42, 4, 300, "R5 compare duration 2");
    status_is(8'hC0, "R5 mismatch flag");

    // R8: program through buffer A
    open_hdr(8'h71, 6, 20); spi_byte(8'h01, 0); spi_byte(8'h02, 0);
    close_and_time(900, "R8 program-through duration");
    expect_byte(8'h01, "R8 page6[20]"); expect_byte(8'h02, "R8 page6[21]");
    rd(8'h0B, 6, 20, 2);
    expect_byte(8'h01, "R8 bufA[20]");
    rd(8'h21, 0, 20, 1);

    // R9 block erase, with R11 ignored commands and R10 status while busy
    run_op(8'h51, 8, 900, "R6 program page 8");
    open_hdr(8'h91, 3, 0); #50; cs_n = 1'b1;
    #200;
    status_is(8'h40, "R10 status while busy");
    open_hdr(8'h11, 0, 10); spi_byte(8'h99, 0); close_frame();
    open_hdr(8'h81, 8, 0); close_frame();
    while (busy) @(posedge clk);
    #1;
    stays_idle(40, "R11 erase during busy not launched");
    expect_byte(8'hAA, "R11 buffer write ignored");
    rd(8'h21, 0, 10, 1);
    expect_byte(8'hFF, "R9 block page4"); rd(8'h0B, 4, 10, 1);
    expect_byte(8'hFF, "R9 block page7 end"); rd(8'h0B, 7, 263, 1);
    expect_byte(8'hAA, "R9 page8 outside block"); rd(8'h0B, 8, 10, 1);
    run_op(8'h91, 9, 2400, "R9 block erase duration");

    // R12: protection
    protect_n = 1'b0;
    open_hdr(8'h51, 1, 0); close_frame();
    stays_idle(40, "R12 protected program refused");
    status_is(8'hE0, "R12 reject flag");
    expect_byte(8'hFF, "R12 page1 untouched"); rd(8'h0B, 1, 10, 1);
    run_op(8'h51, 9, 900, "R12 unprotected page proceeds");
    status_is(8'hC0, "R12 reject flag cleared");
    expect_byte(8'hAA, "R12 page9 programmed"); rd(8'h0B, 9, 10, 1);
    protect_n = 1'b1;

    // R14: short frame
    cs_n = 1'b0; #50; spi_byte(8'h81, 0); spi_byte(8'h00, 0); spi_byte(8'h12, 0); close_frame();
    stays_idle(40, "R14 short frame no launch");
    expect_byte(8'hAA, "R14 page9 intact"); rd(8'h0B, 9, 10, 1);

    // R13: abort
    open_hdr(8'h81, 9, 0); #50; cs_n = 1'b1;
    while (!busy) @(posedge clk);
    repeat (100) @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check(busy, 0, "R13 abort drops busy");
    #30 rst_n = 1'b1;
    #100;
    status_is(8'h80, "R13 flags cleared");
    expect_byte(8'hFF, "R13 reached byte erased"); rd(8'h0B, 9, 10, 1);
    expect_byte(8'h77, "R13 unreached byte kept"); rd(8'h0B, 9, 263, 1);

    repeat (20) @(posedge clk);
    check(exp_v.size(), 0, "R1 all expected bytes seen");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule